// File: doc/BRIEF.md
# Oscillator Start-up Hold Timer

This block keeps the processor core from running until a crystal or ceramic resonator has settled. A start request can come from a power-on event or from a wake from sleep. When the selected clock mode is one of the resonator modes, the block raises a hold that freezes the program counter. It then counts rising edges of the raw oscillator signal and lifts the hold after a fixed number of edges. After a power-on event with the power-up delay enabled, counting waits until that delay has expired. In the logic-level external clock mode, the RC mode and the internal oscillator modes there is no settling time, so a start request makes the core ready at once.

The raw oscillator input is sampled in the system clock domain. Its frequency must stay below half the sampling clock. A single select bit, which picks the external clock source or the internal oscillators (a fast 8 MHz source and a slow 31 kHz source), passes through one register. That register output is the clock-source mux select.

Top module: `ostHoldTimer`

## Requirements
- R1: While reset is held and after it is released with no start request, holdPc, oscReady and sysClkSelInt are all 0.
- R2: For clkMode 0, 1 or 2 (the resonator modes), a start request sets holdPc=1 and oscReady=0 from the next clock edge. After exactly START_COUNT (default 1024) rising edges of oscIn have been counted, holdPc returns to 0 and oscReady becomes 1.
- R3: A power-on request with pwrtEnable=1 holds the core with counting stopped. oscIn edges are ignored until pwrtExpired is seen high, and the count starts from zero at that point.
- R4: A wake request, or a power-on request with pwrtEnable=0, starts counting at once.
- R5: For clkMode 3 (external logic clock), 4 (RC), 5 (internal) and the unused codes 6 and 7, a start request gives holdPc=0 and oscReady=1 from the next clock edge, with no count.
- R6: A start request that arrives while the block is waiting or counting restarts the count from zero.
- R7: A rising edge of oscIn is counted at the clock edge two cycles after the edge that first samples it high. If a start request lands in the same cycle as the final counted edge, the request wins: the hold stays asserted and a fresh count of START_COUNT edges begins.
- R8: oscReady rises in the same cycle that holdPc falls. It stays at 1 until the next start request.
- R9: sysClkSelInt equals clkSelInt delayed by one clock.
- R10: While the block is idle or ready, oscIn edges have no effect on holdPc or oscReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkMode | input | 3 | Clock mode: 0 LP, 1 XT, 2 HS, 3 EC, 4 RC, 5 internal |
| porEvent | input | 1 | One-cycle power-on start request |
| wakeEvent | input | 1 | One-cycle wake-from-sleep start request |
| pwrtEnable | input | 1 | Power-up delay is in use |
| pwrtExpired | input | 1 | Power-up delay has elapsed (level) |
| oscIn | input | 1 | Raw oscillator signal, asynchronous |
| clkSelInt | input | 1 | 1 selects the internal oscillators, 0 the external source |
| holdPc | output | 1 | Freezes the program counter while high |
| oscReady | output | 1 | Oscillator settled |
| sysClkSelInt | output | 1 | Registered clock-source select |

## Verification
A new start request and the final counted oscillator edge can fall in the same cycle. If the request is not handled first, the core would be released for one cycle, or the colliding edge would be credited to the new count. The bench aims a wake request at the exact cycle the 1024th edge is counted, using the stated synchronizer latency. It then checks that holdPc stays high and that oscReady never pulses. Finally it confirms that 1023 more edges still hold the core and that one more edge releases it.

// File: rtl/ostPkg.sv
package ostPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAITP = 2'd1,
    ST_COUNT = 2'd2,
    ST_READY = 2'd3
  } ostState_e;

  typedef struct packed {
    logic clrCount;
    logic countEn;
  } ostStrobe_t;

  localparam logic [2:0] MODE_LP = 3'd0;
  localparam logic [2:0] MODE_XT = 3'd1;
  localparam logic [2:0] MODE_HS = 3'd2;

  function automatic logic isResonator(input logic [2:0] mode);
    return (mode == MODE_LP) || (mode == MODE_XT) || (mode == MODE_HS);
  endfunction

endpackage

// File: rtl/ostEdgeCounter.sv
module ostEdgeCounter
  import ostPkg::*;
#(
  parameter int START_COUNT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscIn,
  input  ostStrobe_t strobe,
  output logic       lastEdge
);

  localparam int CNT_W = (START_COUNT > 1) ? $clog2(START_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(START_COUNT - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   oscEdge;
  logic [CNT_W-1:0]       countQ;

  // Synchronizer chain for the asynchronous oscillator input.
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= oscIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign oscEdge = syncQ[SYNC_STAGES-1] & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          countQ <= '0;
    else if (strobe.clrCount)           countQ <= '0;
    else if (strobe.countEn && oscEdge) countQ <= (countQ == LAST) ? '0 : countQ + 1'b1;
  end

  assign lastEdge = strobe.countEn && oscEdge && (countQ == LAST);

  // R2: the edge counter never runs past its final value
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= LAST);

  // R6: a clear strobe leaves the counter at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCount |=> countQ == '0);

endmodule

// File: rtl/ostControl.sv
module ostControl
  import ostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkMode,
  input  logic       porEvent,
  input  logic       wakeEvent,
  input  logic       pwrtEnable,
  input  logic       pwrtExpired,
  input  logic       clkSelInt,
  input  logic       lastEdge,
  output ostStrobe_t strobe,
  output logic       holdPc,
  output logic       oscReady,
  output logic       sysClkSelInt
);

  ostState_e stateQ, stateD;
  logic      trig;

  assign trig = porEvent | wakeEvent;

  always_comb begin
    stateD          = stateQ;
    strobe.clrCount = 1'b0;
    strobe.countEn  = 1'b0;
    if (trig) begin
      strobe.clrCount = 1'b1;
      if (!isResonator(clkMode))         stateD = ST_READY;
      else if (porEvent && pwrtEnable)   stateD = ST_WAITP;
      else                               stateD = ST_COUNT;
    end else begin
      unique case (stateQ)
        ST_WAITP: if (pwrtExpired) begin
          strobe.clrCount = 1'b1;
          stateD          = ST_COUNT;
        end
        ST_COUNT: begin
          strobe.countEn = 1'b1;
          if (lastEdge) stateD = ST_READY;
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      sysClkSelInt <= 1'b0;
    end else begin
      stateQ       <= stateD;
      sysClkSelInt <= clkSelInt;
    end
  end

  assign holdPc   = (stateQ == ST_WAITP) || (stateQ == ST_COUNT);
  assign oscReady = (stateQ == ST_READY);

  // R2: the final counted edge releases the hold and raises ready
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    (holdPc && !trig && lastEdge) |=> (!holdPc && oscReady));

  // R2, R6, R7: a request in a resonator mode always holds the core
  a_r6_restart_hold: assert property (@(posedge clk) disable iff (!rstN)
    (trig && isResonator(clkMode)) |=> (holdPc && !oscReady));

  // R5: non-resonator modes give no delay
  a_r5_no_delay: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !isResonator(clkMode)) |=> (!holdPc && oscReady));

  // R3: hold is kept while the power-up delay is pending
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAITP && !pwrtExpired && !trig) |=> holdPc);

  // R8: release and ready coincide
  a_r8_ready_on_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdPc) |-> oscReady);

  // R8: ready persists until a new request
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (oscReady && !trig) |=> oscReady);

  // R9: clock select is a one-cycle delayed copy
  a_r9_sel_delay: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> sysClkSelInt == $past(clkSelInt));

endmodule

// File: rtl/ostHoldTimer.sv
module ostHoldTimer
  import ostPkg::*;
#(
  parameter int START_COUNT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkMode,
  input  logic       porEvent,
  input  logic       wakeEvent,
  input  logic       pwrtEnable,
  input  logic       pwrtExpired,
  input  logic       oscIn,
  input  logic       clkSelInt,
  output logic       holdPc,
  output logic       oscReady,
  output logic       sysClkSelInt
);

  ostStrobe_t strobe;
  logic       lastEdge;

  ostControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .clkMode      (clkMode),
    .porEvent     (porEvent),
    .wakeEvent    (wakeEvent),
    .pwrtEnable   (pwrtEnable),
    .pwrtExpired  (pwrtExpired),
    .clkSelInt    (clkSelInt),
    .lastEdge     (lastEdge),
    .strobe       (strobe),
    .holdPc       (holdPc),
    .oscReady     (oscReady),
    .sysClkSelInt (sysClkSelInt)
  );

  ostEdgeCounter #(
    .START_COUNT (START_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .oscIn    (oscIn),
    .strobe   (strobe),
    .lastEdge (lastEdge)
  );

endmodule

// File: tb/ostHoldTimer_bench.sv
module ostHoldTimer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NEDGE      = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkMode = 3'd1;
  logic       porEvent = 1'b0;
  logic       wakeEvent = 1'b0;
  logic       pwrtEnable = 1'b0;
  logic       pwrtExpired = 1'b0;
  logic       oscIn = 1'b0;
  logic       clkSelInt = 1'b0;
  logic       holdPc, oscReady, sysClkSelInt;

  int vectors = 0;
  int miscompares = 0;
  logic prevHold = 1'b0;
  int   badRelease = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ostHoldTimer u_ostHoldTimer (
    .clk (clk), .rstN (rstN), .clkMode (clkMode),
    .porEvent (porEvent), .wakeEvent (wakeEvent),
    .pwrtEnable (pwrtEnable), .pwrtExpired (pwrtExpired),
    .oscIn (oscIn), .clkSelInt (clkSelInt),
    .holdPc (holdPc), .oscReady (oscReady), .sysClkSelInt (sysClkSelInt)
  );

  // R8 monitor: every fall of holdPc must come with oscReady high
  always @(negedge clk) begin
    if (rstN && prevHold && !holdPc && !oscReady) badRelease++;
    prevHold = holdPc;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseOsc(input int n);
    for (int i = 0; i < n; i++) begin
      oscIn = 1'b1; idle(2);
      oscIn = 1'b0; idle(2);
    end
  endtask

  task automatic request(input logic por, input logic wake);
    porEvent = por; wakeEvent = wake;
    idle(1);
    porEvent = 1'b0; wakeEvent = 1'b0;
  endtask

  task automatic expectHeld(input string tag);
    chk({tag, " holdPc"}, holdPc, 1);
    chk({tag, " oscReady"}, oscReady, 0);
  endtask

  task automatic expectReady(input string tag);
    chk({tag, " holdPc"}, holdPc, 0);
    chk({tag, " oscReady"}, oscReady, 1);
  endtask

  // Full count from the current start point: 1023 edges hold, one more releases.
  task automatic countOut(input string tag);
    pulseOsc(NEDGE - 1); idle(6);
    expectHeld({tag, " after 1023 edges"});
    pulseOsc(1); idle(6);
    expectReady({tag, " after 1024 edges"});
  endtask

  task automatic testReset();
    chk("R1 reset holdPc", holdPc, 0);
    chk("R1 reset oscReady", oscReady, 0);
    chk("R1 reset sysClkSelInt", sysClkSelInt, 0);
  endtask

  task automatic testSelect();
    clkSelInt = 1'b1; #1;
    chk("R9 select before edge", sysClkSelInt, 0);
    idle(1);
    chk("R9 select after edge", sysClkSelInt, 1);
    clkSelInt = 1'b0; idle(1);
    chk("R9 select back to 0", sysClkSelInt, 0);
  endtask

  task automatic testNoDelay();
    for (int m = 3; m <= 7; m++) begin
      clkMode = 3'(m);
      request(1'b0, 1'b1);
      expectReady($sformatf("R5 mode %0d wake", m));
      request(1'b1, 1'b0);
      expectReady($sformatf("R5 mode %0d por", m));
    end
    pulseOsc(5); idle(4);
    expectReady("R10 edges while ready");
  endtask

  task automatic testPorNoPwrt();
    clkMode = 3'd1; pwrtEnable = 1'b0;
    request(1'b1, 1'b0);
    expectHeld("R2 XT por start");
    countOut("R4 XT por no pwrt");
    idle(20);
    expectReady("R8 ready persists");
  endtask

  task automatic testPorPwrt();
    clkMode = 3'd2; pwrtEnable = 1'b1; pwrtExpired = 1'b0;
    request(1'b1, 1'b0);
    pulseOsc(1100); idle(4);
    expectHeld("R3 HS waiting for pwrt");
    pwrtExpired = 1'b1; idle(2);
    countOut("R3 HS after pwrt");
    pwrtExpired = 1'b0; pwrtEnable = 1'b0;
  endtask

  task automatic testRestart();
    clkMode = 3'd0;
    request(1'b0, 1'b1);
    expectHeld("R6 LP wake start");
    pulseOsc(600);
    request(1'b0, 1'b1);
    expectHeld("R6 LP restart");
    countOut("R6 LP restarted count");
  endtask

  task automatic testCollision();
    int readySeen;
    clkMode = 3'd1;
    request(1'b0, 1'b1);
    pulseOsc(NEDGE - 1); idle(2);
    readySeen = 0;
    // final edge: raised here, counted two clock edges after first sample
    oscIn = 1'b1; idle(1);
    readySeen += oscReady;
    idle(1);
    readySeen += oscReady;
    wakeEvent = 1'b1; idle(1);
    readySeen += oscReady;
    wakeEvent = 1'b0; oscIn = 1'b0; idle(1);
    readySeen += oscReady;
    idle(4);
    readySeen += oscReady;
    chk("R7 no ready pulse on collision", readySeen, 0);
    expectHeld("R7 collision request wins");
    countOut("R7 fresh count after collision");
  endtask

  task automatic testReadyDrop();
    clkMode = 3'd0;
    request(1'b1, 1'b0);
    expectHeld("R8 ready drops on new request");
    countOut("R8 second count");
    chk("R8 release coincides with ready", badRelease, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    testReset();
    rstN = 1'b1;
    idle(3);
    testReset();
    testSelect();
    testNoDelay();
    testPorNoPwrt();
    testPorPwrt();
    testRestart();
    testCollision();
    testReadyDrop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule